// File: doc/BRIEF.md
# Dual-Modulus Main Frequency Divider

This block divides a fast input clock by a programmable whole number. It has three parts: a prescaler that divides by 10 or by 11, a swallow counter, and a main counter. The swallow counter holds the modulus-select line high for the first A prescaler cycles of each output period. The main counter counts M+1 prescaler cycles per period. With the prescaler in use, the overall ratio is 10·(M+1)+A. When the active-low prescaler enable is driven high, the prescaler is bypassed and held idle, and the main counter then divides the input clock directly by M+1.

The output `fp` is a pulse one input clock wide, produced once per period at the main counter's terminal count. The modulus-select line and the raw prescaler pulse are both brought out as monitor outputs. New M, A and bypass settings may be driven at any time. They take effect only at the terminal count, so each output period runs entirely on one set of values. A synchronous reset loads the settings present on the inputs and starts a fresh period.

Valid settings are 1 ≤ M ≤ 511 and A ≤ M+1, with A at most 15. The programming logic that feeds M and A is outside this block.

Top module: `dual_mod_divider`

## Requirements
- R1: With `pre_en_n` low, the spacing between consecutive `fp` pulses is exactly 10·(M+1)+A input clocks.
- R2: With `pre_en_n` low and A=0, the ratio is 10·(M+1) and `msel` stays low for the whole period.
- R3: With `pre_en_n` low, `msel` is high during exactly the first 11·A input clocks of each period, which are the first A prescaler cycles. It changes only at the end of a prescaler cycle.
- R4: With `pre_en_n` low, `pre_out` gives a pulse one clock wide at the end of each prescaler cycle, so there are M+1 pulses per period, and the last of them coincides with `fp`.
- R5: With `pre_en_n` high, the `fp` spacing is M+1 input clocks, and both `msel` and `pre_out` stay low.
- R6: M, A and `pre_en_n` are sampled only in the clock cycle in which `fp` is high, or during reset. A change made partway through a period does not alter that period's length, and it governs the next period.
- R7: `fp` is high for exactly one input clock per period.
- R8: While `rst` is high, `fp` and `pre_out` are low, and `msel` equals (A≠0 and `pre_en_n` low). The first `fp` appears in the ratio-th clock cycle, counting the first cycle with `rst` low as cycle 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high; loads the settings |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow count A |
| pre_en_n | input | 1 | Prescaler enable, active low; high selects bypass |
| fp | output | 1 | Divided output pulse, one clock wide |
| msel | output | 1 | Modulus select: high selects divide-by-11 |
| pre_out | output | 1 | Raw prescaler end-of-cycle pulse |

## Verification
A wrong count in the prescaler, swallow or main counter shows up at once as an `fp` spacing that differs from the arithmetic ratio. It also changes the number of clocks per period during which `msel` is high, and the number of `pre_out` pulses per period. All three are checked within the first full period after a setting takes effect. A fault in the reload path, where a setting is picked up early or late, makes the period in progress the wrong length, and the mid-period change tests detect this within that same period.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
    localparam int M_W     = 9;
    localparam int A_W     = 4;
    localparam int PRE_LOW = 10;
    localparam int PC_W    = $clog2(PRE_LOW + 1);

    typedef struct packed {
        logic           bypass;
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
    } dmd_cfg_t;

    // last prescaler state: 10 states normally, 11 while modulus select is high
    function automatic logic [PC_W-1:0] pre_last(input logic sel_hi);
        return sel_hi ? PC_W'(PRE_LOW) : PC_W'(PRE_LOW - 1);
    endfunction
endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler import dmd_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic sel_hi,
    output logic tick,
    output logic raw
);
    logic [PC_W-1:0] pc_q;
    logic            at_last;

    assign at_last = (pc_q == pre_last(sel_hi));
    assign tick    = bypass | at_last;
    assign raw     = !bypass && at_last;

    always_ff @(posedge clk) begin
        if (rst || bypass)  pc_q <= '0;
        else if (at_last)   pc_q <= '0;
        else                pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow import dmd_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           reload,
    input  logic [A_W-1:0] load_a,
    input  logic           tick,
    input  logic           bypass,
    output logic           sel_hi
);
    logic [A_W-1:0] ac_q;

    assign sel_hi = !bypass && (ac_q != '0);

    always_ff @(posedge clk) begin
        if (rst || reload)            ac_q <= load_a;
        else if (tick && ac_q != '0)  ac_q <= ac_q - 1'b1;
    end
endmodule

// File: rtl/dmd_mcount.sv
module dmd_mcount import dmd_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic [M_W-1:0] load_m,
    output logic           term
);
    logic [M_W-1:0] mc_q;

    assign term = tick && (mc_q == '0);

    always_ff @(posedge clk) begin
        if (rst)            mc_q <= load_m;
        else if (term)      mc_q <= load_m;
        else if (tick)      mc_q <= mc_q - 1'b1;
    end
endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider import dmd_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic           pre_en_n,
    output logic           fp,
    output logic           msel,
    output logic           pre_out
);
    dmd_cfg_t cfg_q;
    dmd_cfg_t cfg_next;
    logic     pre_tick;
    logic     term;

    always_comb begin
        cfg_next.bypass = pre_en_n;
        cfg_next.a      = a_val;
        cfg_next.m      = m_val;
    end

    // settings for the running period change only at terminal count or reset
    always_ff @(posedge clk) begin
        if (rst || term) cfg_q <= cfg_next;
    end

    dmd_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .bypass (cfg_q.bypass),
        .sel_hi (msel),
        .tick   (pre_tick),
        .raw    (pre_out)
    );

    dmd_swallow u_swl (
        .clk    (clk),
        .rst    (rst),
        .reload (term),
        .load_a (cfg_next.a),
        .tick   (pre_tick),
        .bypass (cfg_q.bypass),
        .sel_hi (msel)
    );

    dmd_mcount u_mct (
        .clk    (clk),
        .rst    (rst),
        .tick   (pre_tick),
        .load_m (cfg_next.m),
        .term   (term)
    );

    assign fp = term;
endmodule

// File: rtl/dmd_checker.sv
module dmd_checker import dmd_pkg::*; (
    input logic     clk,
    input logic     rst,
    input logic     fp,
    input logic     msel,
    input logic     pre_out,
    input logic     pre_tick,
    input dmd_cfg_t cfg
);
    AST_FP_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        fp |=> !fp);                                                    // R7

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg.bypass |-> (!msel && !pre_out));                            // R5

    AST_MSEL_FALL_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(msel)) |-> $past(pre_tick));              // R3

    AST_RAW_PULSE: assert property (@(posedge clk) disable iff (rst)
        pre_out |=> !pre_out);                                          // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fp)) |-> $stable(cfg));                  // R6
endmodule

bind dual_mod_divider dmd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .fp       (fp),
    .msel     (msel),
    .pre_out  (pre_out),
    .pre_tick (pre_tick),
    .cfg      (cfg_q)
);

// File: tb/dual_mod_divider_bench.sv
module dual_mod_divider_bench;
    localparam int CLK_P    = 10;
    localparam int WAIT_MAX = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] m_in = 9'd5;
    logic [3:0] a_in = 4'd3;
    logic       pre_en_n = 1'b0;
    logic       fp, msel, pre_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_mod_divider u_dual_mod_divider (
        .clk(clk), .rst(rst), .m_val(m_in), .a_val(a_in),
        .pre_en_n(pre_en_n), .fp(fp), .msel(msel), .pre_out(pre_out)
    );

    function automatic int ratio(input int m, input int a, input bit byp);
        return byp ? (m + 1) : (10 * (m + 1) + a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic setcfg(input int m, input int a, input bit byp);
        m_in = 9'(m); a_in = 4'(a); pre_en_n = byp;
    endtask

    // advance to the next negedge at which fp is high
    task automatic sync_fp();
        int k = 0;
        do begin
            @(negedge clk); k++;
        end while (!fp && k < WAIT_MAX);
        if (!fp) check(1'b0, "watchdog fp", k, 0);
    endtask

    // from an fp negedge: length of next period plus msel/raw counts over it
    task automatic run_period(output int len, output int ms, output int rw);
        len = 0; ms = 0; rw = 0;
        do begin
            @(negedge clk); len++;
            if (msel) ms++;
            if (pre_out) rw++;
        end while (!fp && len < WAIT_MAX);
    endtask

    task automatic one_setting(input int m, input int a, input bit byp);
        int len, ms, rw;
        setcfg(m, a, byp);
        sync_fp();            // new values sampled here
        run_period(len, ms, rw);
        if (byp) begin
            check(len == m + 1, "R5 bypass ratio", len, m + 1);
            check(ms == 0 && rw == 0, "R5 monitors quiet", ms + rw, 0);
        end else begin
            check(len == ratio(m, a, 0), a == 0 ? "R2 ratio A=0" : "R1 ratio", len, ratio(m, a, 0));
            check(ms == 11 * a, "R3 msel clocks", ms, 11 * a);
            check(rw == m + 1, "R4 raw pulses", rw, m + 1);
        end
    endtask

    task automatic reset_check(input int m, input int a, input bit byp);
        int k;
        @(negedge clk);
        rst = 1'b1; setcfg(m, a, byp);
        repeat (3) @(negedge clk);
        check(fp == 1'b0 && pre_out == 1'b0, "R8 reset outputs", {fp, pre_out}, 0);
        check(msel == (a != 0 && !byp), "R8 reset msel", msel, (a != 0 && !byp));
        rst = 1'b0;
        k = 1;
        while (!fp && k < WAIT_MAX) begin
            @(negedge clk); k++;
        end
        check(k == ratio(m, a, byp), "R8 first period", k, ratio(m, a, byp));
    endtask

    // change settings partway through a period
    task automatic mid_change(input int m0, input int a0, input bit b0,
                              input int m1, input int a1, input bit b1, input int at);
        int len, ms, rw;
        setcfg(m0, a0, b0);
        sync_fp();
        sync_fp();
        len = 0;
        do begin
            @(negedge clk); len++;
            if (len == at) setcfg(m1, a1, b1);
        end while (!fp && len < WAIT_MAX);
        check(len == ratio(m0, a0, b0), "R6 period kept", len, ratio(m0, a0, b0));
        run_period(len, ms, rw);
        check(len == ratio(m1, a1, b1), "R6 next period new", len, ratio(m1, a1, b1));
    endtask

    // fp width
    task automatic width_check(input int m, input bit byp);
        setcfg(m, 0, byp);
        sync_fp(); sync_fp();
        @(negedge clk);
        check(fp == 1'b0, "R7 fp one clock", fp, 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        check(1'b0, "watchdog global", 0, 1);
        summary();
    end

    initial begin
        reset_check(5, 3, 1'b0);
        reset_check(4, 0, 1'b1);
        reset_check(2, 3, 1'b0);

        for (int m = 1; m <= 16; m++)
            for (int a = 0; a <= ((m + 1 < 15) ? m + 1 : 15); a++)
                one_setting(m, a, 1'b0);
        one_setting(300, 7, 1'b0);
        one_setting(511, 15, 1'b0);
        one_setting(511, 0, 1'b0);

        for (int m = 1; m <= 40; m++) one_setting(m, m % 16, 1'b1);
        one_setting(511, 9, 1'b1);

        mid_change(5, 3, 1'b0, 2, 0, 1'b1, 20);
        mid_change(7, 0, 1'b1, 3, 4, 1'b0, 3);
        mid_change(9, 10, 1'b0, 12, 13, 1'b0, 95);
        mid_change(4, 2, 1'b0, 4, 5, 1'b0, 1);

        width_check(1, 1'b1);
        width_check(1, 1'b0);

        reset_check(20, 15, 1'b0);
        summary();
    end
endmodule